// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is one stage of a synchronous binary up-counter. It is four bits wide by default. All of its state bits change together on the rising clock edge. On each edge the stage does one of four things: it clears to zero, it loads a parallel data word, it increments, or it holds. Clear has the highest priority, then load, then increment, then hold. The stage increments only when both of its count enables are high. A parameter chooses how the clear acts. It can act at once, without waiting for a clock edge, or it can wait for the next rising edge like the other modes.

A combinational terminal-count output goes high when the count is at its all-ones value and the second enable is high. The first enable has no effect on this output. To build a wider synchronous counter from several stages, feed each stage's terminal-count output into the next stage's second enable. Share the clock, and share the first enable as a common run control. No extra gating is needed. With the synchronous clear, a shorter count cycle is made by decoding the wanted last value and driving the clear input from that decode.

Top module: `presettable_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and carry_o is 0, whatever the other inputs are.
- R2: When load_ni is low and clr_ni is high at a rising edge, count_o takes the value of data_i after that edge, whatever the levels of en_p_i and en_t_i.
- R3: With ASYNC_CLR = 0, a low clr_ni does not change count_o before the next rising edge. After that edge count_o is 0, whatever the levels of load_ni, en_p_i and en_t_i.
- R4: With ASYNC_CLR = 1, a low clr_ni drives count_o to 0 without any clock edge. count_o stays at 0 through clock edges while clr_ni remains low.
- R5: When clr_ni and load_ni are both high and en_p_i and en_t_i are both high at a rising edge, count_o increases by one. From the all-ones value (15 at WIDTH = 4) it wraps to 0.
- R6: When clr_ni and load_ni are both high and at least one of en_p_i and en_t_i is low, count_o holds its value across the edge.
- R7: carry_o is high exactly when count_o is all ones and en_t_i is high. en_p_i does not affect it.
- R8: Two stages form an 8-bit synchronous counter when they share the clock, and the low stage's carry_o drives the high stage's en_t_i. The high count is the upper nibble of the 8-bit value, and the pair wraps from 255 to 0.
- R9: With ASYNC_CLR = 0, driving clr_ni low whenever count_o equals 9 makes the stage cycle through 0..9 and then return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset to zero |
| clr_ni | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_ni | input | 1 | Active-low parallel load, synchronous |
| en_p_i | input | 1 | Count enable that does not gate carry_o |
| en_t_i | input | 1 | Count enable that also gates carry_o |
| data_i | input | WIDTH | Parallel preset value |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry, high at all ones with en_t_i high |

## Verification
A wrong mode priority shows up on count_o at the first rising edge where two controls are active together. For example, a load that beats a clear leaves data_i where zero was expected. A faulty increment or wrap shows within one edge of the count passing all ones. A wrong carry decode shows at once on carry_o, and one edge later in the high stage of a cascade, where the upper nibble fails to follow the low stage's roll-over. A clear wired to the wrong timing shows before any edge: count_o is either already zero while it should still hold, or still holds while it should already be zero.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      en_p_i,
  input  logic      en_t_i,
  output cnt_mode_e mode_o
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)               mode_o = MODE_CLEAR;
    else if (!load_ni)         mode_o = MODE_LOAD;
    else if (en_p_i && en_t_i) mode_o = MODE_COUNT;
    else                       mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  cnt_mode_e        mode_i,
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] next_o
);
  always_comb begin
    unique case (mode_i)
      MODE_CLEAR: next_o = '0;
      MODE_LOAD:  next_o = data_i;
      MODE_COUNT: next_o = count_i + WIDTH'(1);
      default:    next_o = count_i;
    endcase
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             en_t_i,
  output logic             carry_o
);
  // en_p deliberately excluded so a cascade can stall without losing carry
  assign carry_o = en_t_i & (&count_i);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_p_i,
  input  logic             en_t_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] CountMax = {WIDTH{1'b1}};

  cnt_mode_e        mode;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  cnt_mode_dec u_mode_dec (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .mode_o  (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode_i  (mode),
    .count_i (count_q),
    .data_i  (data_i),
    .next_o  (count_d)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .count_i (count_q),
    .en_t_i  (en_t_i),
    .carry_o (carry_o)
  );

  generate
    if (ASYNC_CLR) begin : g_async_clr
      logic arst_n;
      assign arst_n = rst_ni & clr_ni;
      always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) count_q <= '0;
        else         count_q <= count_d;
      end

      p_async_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |-> count_o == '0);
    end else begin : g_sync_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
      end

      p_sync_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_ni |=> count_o == '0);
    end
  endgenerate

  assign count_o = count_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (count_o == $past(data_i)) || !clr_ni);

  p_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i)
      |=> (count_o == $past(count_o) + WIDTH'(1)) || !clr_ni);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(en_p_i && en_t_i))
      |=> $stable(count_o) || !clr_ni);

  p_carry_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == CountMax) && en_t_i);

  p_carry_seen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == CountMax && en_t_i) |-> carry_o);

  always_comb begin
    if (!rst_ni) p_reset_r1: assert (count_q == '0);
  end
endmodule

// File: tb/presettable_counter_bench.sv
module presettable_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_a = 1'b1, clr_b = 1'b1;
  logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] cnt_a, cnt_b, cnt_lo, cnt_hi;
  logic       cy_a, cy_b, cy_lo, cy_hi;
  logic       cas_en = 1'b0;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_presettable_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_a), .load_ni(load_n),
    .en_p_i(en_p), .en_t_i(en_t), .data_i(data), .count_o(cnt_a), .carry_o(cy_a));

  presettable_counter #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_presettable_counter_async (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_b), .load_ni(load_n),
    .en_p_i(en_p), .en_t_i(en_t), .data_i(data), .count_o(cnt_b), .carry_o(cy_b));

  presettable_counter #(.WIDTH(4)) u_presettable_counter_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(1'b1), .load_ni(1'b1),
    .en_p_i(cas_en), .en_t_i(1'b1), .data_i(4'd0), .count_o(cnt_lo), .carry_o(cy_lo));

  presettable_counter #(.WIDTH(4)) u_presettable_counter_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(1'b1), .load_ni(1'b1),
    .en_p_i(cas_en), .en_t_i(cy_lo), .data_i(4'd0), .count_o(cnt_hi), .carry_o(cy_hi));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic t_reset();  // R1
    data = 4'hF; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R1 count", cnt_a, 0);
    chk("R1 carry", cy_a, 0);
    chk("R1 async count", cnt_b, 0);
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_load();  // R2
    data = 4'hA; load_n = 1'b0; en_p = 1'b0; en_t = 1'b0;
    tick();
    chk("R2 load enables low", cnt_a, 10);
    data = 4'h3; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R2 load enables high", cnt_a, 3);
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_count_wrap();  // R5 R7 R6
    data = 4'd13; load_n = 1'b0;
    tick();
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R5 step", cnt_a, 14);
    chk("R7 no carry below max", cy_a, 0);
    tick();
    chk("R5 step to max", cnt_a, 15);
    chk("R7 carry at max", cy_a, 1);
    en_p = 1'b0;
    #1;
    chk("R7 carry ignores en_p", cy_a, 1);
    tick();
    chk("R6 hold en_p low", cnt_a, 15);
    en_t = 1'b0; en_p = 1'b1;
    #1;
    chk("R7 carry gated by en_t", cy_a, 0);
    tick();
    chk("R6 hold en_t low", cnt_a, 15);
    en_t = 1'b1;
    tick();
    chk("R5 wrap", cnt_a, 0);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_sync_clr();  // R3
    data = 4'd7; load_n = 1'b0;
    tick();
    clr_a = 1'b0; load_n = 1'b0; data = 4'd9; en_p = 1'b1; en_t = 1'b1;
    #2;
    chk("R3 no change before edge", cnt_a, 7);
    tick();
    chk("R3 cleared over load", cnt_a, 0);
    clr_a = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_async_clr();  // R4
    data = 4'd5; load_n = 1'b0;
    tick();
    load_n = 1'b1;
    chk("R4 preload", cnt_b, 5);
    clr_b = 1'b0;
    #1;
    chk("R4 immediate clear", cnt_b, 0);
    en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R4 held through edge", cnt_b, 0);
    clr_b = 1'b1;
    tick();
    chk("R4 counts after release", cnt_b, 1);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_cascade();  // R8
    int exp_v = 0;
    int bad = 0;
    chk("R8 start", {cnt_hi, cnt_lo}, 0);
    cas_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      tick();
      exp_v = (exp_v + 1) % 256;
      if ({cnt_hi, cnt_lo} != exp_v[7:0] && bad == 0) begin
        bad = 1;
        chk("R8 cascade value", {cnt_hi, cnt_lo}, exp_v);
      end
    end
    if (bad == 0) chk("R8 cascade value", {cnt_hi, cnt_lo}, 300 % 256);
    cas_en = 1'b0;
    tick();
    chk("R8 hold when stopped", {cnt_hi, cnt_lo}, 300 % 256);
  endtask

  task automatic t_mod10();  // R9
    int bad = 0;
    data = 4'd0; load_n = 1'b0;
    tick();
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      clr_a = (cnt_a != 4'd9);
      tick();
      if (cnt_a != (i % 10) && bad == 0) begin
        bad = 1;
        chk("R9 truncated cycle", cnt_a, i % 10);
      end
    end
    if (bad == 0) chk("R9 truncated cycle", cnt_a, 5);
    clr_a = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_load();
    t_count_wrap();
    t_sync_clr();
    t_async_clr();
    t_cascade();
    t_mod10();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule